// File: doc/BRIEF.md
# Write-Set-Clear Control Register Bank

This block is a small bank of control registers on the transceiver side of a link. The link controller reaches it through a plain register-access port: an address, a write strobe and a write byte, with a read byte that always follows the current address. Each read/write register occupies three consecutive addresses. A write to the first one replaces the register. A write to the second one ORs the byte into it. A write to the third one clears every bit that is 1 in the byte. Any of the three addresses reads back the current value.

The bank holds three registers. The first is a read-only debug byte that shows two live line-state inputs. The second is a free scratch byte. The third is a routing-control byte whose bits drive enables for grounding the ID pin, for routing UART transmit and receive, and for the audio paths. The access port carries single control transfers, not a data stream, so it has no valid/ready handshake. A write strobe is always accepted in the cycle it is presented, and every other pin is a plain level.

Top module: `wsc_reg_bank`

## Requirements
- R1: A read at address 15h returns {6'b0, line_state_i[1:0]}, taken from the live inputs in the same cycle.
- R2: The scratch byte reads back at any of 16h, 17h and 18h, and a write to 16h replaces it with the write byte.
- R3: A write to 17h ORs the write byte into the scratch byte, and a write to 18h clears the scratch bits that are 1 in the write byte.
- R4: The routing byte reads back at 19h, 1Ah and 1Bh. A write to 19h replaces it, a write to 1Ah ORs the byte in, and a write to 1Bh clears the bits that are 1 in the byte.
- R5: Routing-byte bits 0 and 7 always read 0, whatever is written, set or cleared.
- R6: Routing-byte bit 1 drives id_gnd_en, bit 2 drives uart_tx_dm_en, bit 3 drives uart_rx_dp_en, bit 4 drives spk_left_en, bit 5 drives spk_right_en and bit 6 drives mic_en.
- R7: dp_spk_r_en is 1 while bit 5 or bit 6 of the routing byte is 1, and 0 only when both bits are 0.
- R8: data1_o is 1 while routing bit 3 is 0. While bit 3 is 1, data1_o follows dp_rx_i.
- R9: A write takes effect at the clock edge that samples the strobe. A read in the same cycle returns the value from before the write.
- R10: A write to 15h or to any address outside 15h..1Bh changes nothing, and a read at an address outside 15h..1Bh returns 00h.
- R11: While rst is high at a clock edge, the scratch byte and the routing byte return to 00h.
- R12: Changes to the scratch byte leave the routing byte and all routing outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Register address |
| acc_wr | input | 1 | Write strobe, sampled at the rising edge |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for acc_addr (combinational) |
| line_state_i | input | 2 | Live line-state bits shown in the debug byte |
| dp_rx_i | input | 1 | Received UART level coming from DP |
| id_gnd_en | output | 1 | Pull the ID pin to ground |
| uart_tx_dm_en | output | 1 | Route UART transmit onto DM |
| uart_rx_dp_en | output | 1 | Route UART receive from DP |
| spk_left_en | output | 1 | Connect DM to the left speaker |
| spk_right_en | output | 1 | Right-speaker enable bit |
| mic_en | output | 1 | Microphone enable bit |
| dp_spk_r_en | output | 1 | Connect DP to the right speaker |
| data1_o | output | 1 | Data line 1 level: forced high unless receive routing is on |

## Verification
The bench drives set and clear writes whose bytes overlap with the bits already held, so that a design which treats the set alias as a replace, or applies a clear without inverting the mask, reads back the wrong scratch value. It sets and clears the two read-only routing bits through every alias. A design that stores them then shows bit 0 or bit 7 as 1. It clears the right-speaker and microphone bits one at a time, so that a shared right-speaker path that copies only one of them drops out too early or stays on too long. It also reads in the same cycle as a write, writes the debug address and unused addresses, and toggles the receive-route bit. These steps catch a read that shows the new value early, a stray write that lands in a register, and a data line 1 that is not held high.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } wsc_op_e;

  // Number of addresses each read/write register occupies.
  localparam int ALIAS_SPAN = 3;

  // Bit positions inside the routing byte.
  localparam int RT_ID_GND  = 1;
  localparam int RT_UART_TX = 2;
  localparam int RT_UART_RX = 3;
  localparam int RT_SPK_L   = 4;
  localparam int RT_SPK_R   = 5;
  localparam int RT_MIC     = 6;

endpackage

// File: rtl/wsc_addr_dec.sv
module wsc_addr_dec
  import wsc_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output wsc_op_e           op
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(ALIAS_SPAN);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE;
    hit    = (addr >= BASE) && (offset < SPAN);
    op     = OP_NONE;
    if (hit && wr) begin
      case (offset)
        ADDR_W'(0): op = OP_WRITE;
        ADDR_W'(1): op = OP_SET;
        default:    op = OP_CLEAR;
      endcase
    end
  end

endmodule

// File: rtl/wsc_reg.sv
module wsc_reg
  import wsc_pkg::*;
#(
  parameter int               DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  wsc_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] KEEP = ~RO_MASK;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    case (op)
      OP_WRITE: nxt = wdata;
      OP_SET:   nxt = q | wdata;
      OP_CLEAR: nxt = q & ~wdata;
      default:  nxt = q;
    endcase
  end

  // Read-only bits are never stored, so they read as zero.
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL & KEEP;
    else     q <= nxt & KEEP;
  end

endmodule

// File: rtl/wsc_route.sv
module wsc_route
  import wsc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ctl,
  input  logic              dp_rx_i,
  output logic              id_gnd_en,
  output logic              uart_tx_dm_en,
  output logic              uart_rx_dp_en,
  output logic              spk_left_en,
  output logic              spk_right_en,
  output logic              mic_en,
  output logic              dp_spk_r_en,
  output logic              data1_o
);

  always_comb begin
    id_gnd_en     = ctl[RT_ID_GND];
    uart_tx_dm_en = ctl[RT_UART_TX];
    uart_rx_dp_en = ctl[RT_UART_RX];
    spk_left_en   = ctl[RT_SPK_L];
    spk_right_en  = ctl[RT_SPK_R];
    mic_en        = ctl[RT_MIC];
    // The right-speaker path is shared by the speaker and microphone enables.
    dp_spk_r_en   = ctl[RT_SPK_R] | ctl[RT_MIC];
    // Data line 1 idles high unless receive routing is enabled.
    data1_o       = ctl[RT_UART_RX] ? dp_rx_i : 1'b1;
  end

endmodule

// File: rtl/wsc_reg_bank.sv
module wsc_reg_bank
  import wsc_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter int                LS_W        = 2,
  parameter logic [ADDR_W-1:0] DBG_ADDR    = 8'h15,
  parameter logic [ADDR_W-1:0] SCR_BASE    = 8'h16,
  parameter logic [ADDR_W-1:0] RT_BASE     = 8'h19,
  parameter logic [DATA_W-1:0] RT_RO_MASK  = 8'h81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic [LS_W-1:0]   line_state_i,
  input  logic              dp_rx_i,
  output logic              id_gnd_en,
  output logic              uart_tx_dm_en,
  output logic              uart_rx_dp_en,
  output logic              spk_left_en,
  output logic              spk_right_en,
  output logic              mic_en,
  output logic              dp_spk_r_en,
  output logic              data1_o
);

  localparam int NUM_RW = 2;
  localparam int IDX_SCR = 0;
  localparam int IDX_RT  = 1;
  localparam logic [NUM_RW*ADDR_W-1:0] BASE_V = {RT_BASE, SCR_BASE};
  localparam logic [NUM_RW*DATA_W-1:0] RO_V   = {RT_RO_MASK, {DATA_W{1'b0}}};

  logic    [NUM_RW-1:0]             rw_hit;
  wsc_op_e                          rw_op [NUM_RW];
  logic    [NUM_RW-1:0][DATA_W-1:0] reg_q;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    wsc_addr_dec #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE_V[i*ADDR_W +: ADDR_W])
    ) u_dec (
      .addr (acc_addr),
      .wr   (acc_wr),
      .hit  (rw_hit[i]),
      .op   (rw_op[i])
    );

    wsc_reg #(
      .DATA_W  (DATA_W),
      .RST_VAL ({DATA_W{1'b0}}),
      .RO_MASK (RO_V[i*DATA_W +: DATA_W])
    ) u_reg (
      .clk   (clk),
      .rst   (rst),
      .op    (rw_op[i]),
      .wdata (acc_wdata),
      .q     (reg_q[i])
    );
  end

  // Read mux: debug byte, then whichever alias window the address falls in.
  always_comb begin
    acc_rdata = '0;
    if (acc_addr == DBG_ADDR) acc_rdata = DATA_W'(line_state_i);
    for (int i = 0; i < NUM_RW; i++) begin
      if (rw_hit[i]) acc_rdata = reg_q[i];
    end
  end

  wsc_route #(.DATA_W(DATA_W)) u_route (
    .ctl           (reg_q[IDX_RT]),
    .dp_rx_i       (dp_rx_i),
    .id_gnd_en     (id_gnd_en),
    .uart_tx_dm_en (uart_tx_dm_en),
    .uart_rx_dp_en (uart_rx_dp_en),
    .spk_left_en   (spk_left_en),
    .spk_right_en  (spk_right_en),
    .mic_en        (mic_en),
    .dp_spk_r_en   (dp_spk_r_en),
    .data1_o       (data1_o)
  );

  wire unused_scr = ^reg_q[IDX_SCR][0];

endmodule

// File: rtl/wsc_reg_bank_chk.sv
module wsc_reg_bank_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter int                LS_W     = 2,
  parameter logic [ADDR_W-1:0] DBG_ADDR = 8'h15,
  parameter logic [ADDR_W-1:0] SCR_BASE = 8'h16,
  parameter logic [ADDR_W-1:0] RT_BASE  = 8'h19
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic [LS_W-1:0]   line_state_i,
  input logic              dp_rx_i,
  input logic [DATA_W-1:0] scr_q,
  input logic [DATA_W-1:0] rt_q,
  input logic              id_gnd_en,
  input logic              uart_tx_dm_en,
  input logic              uart_rx_dp_en,
  input logic              spk_left_en,
  input logic              spk_right_en,
  input logic              mic_en,
  input logic              dp_spk_r_en,
  input logic              data1_o
);

  localparam logic [ADDR_W-1:0] SCR_SET = SCR_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SCR_CLR = SCR_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RT_SET  = RT_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RT_CLR  = RT_BASE + ADDR_W'(2);

  logic in_scr, in_rt, stray_wr;
  always_comb begin
    in_scr   = (acc_addr >= SCR_BASE) && (acc_addr <= SCR_CLR);
    in_rt    = (acc_addr >= RT_BASE) && (acc_addr <= RT_CLR);
    stray_wr = acc_wr && !in_scr && !in_rt;
  end

  p_dbg_live_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_addr == DBG_ADDR) |-> (acc_rdata == DATA_W'(line_state_i)));

  p_scr_write_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr == SCR_BASE) |=> (scr_q == $past(acc_wdata)));

  p_scr_set_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr == SCR_SET) |=> (scr_q == ($past(scr_q) | $past(acc_wdata))));

  p_scr_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr == SCR_CLR) |=> (scr_q == ($past(scr_q) & ~$past(acc_wdata))));

  p_rt_set_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_addr == RT_SET) |=> ((rt_q | 8'h81) == ($past(rt_q) | $past(acc_wdata) | 8'h81)));

  p_rt_ro_r5: assert property (@(posedge clk) disable iff (rst)
    in_rt |-> (acc_rdata[0] == 1'b0 && acc_rdata[7] == 1'b0));

  p_route_map_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_addr == RT_BASE) |-> (acc_rdata[6:1] ==
      {mic_en, spk_right_en, spk_left_en, uart_rx_dp_en, uart_tx_dm_en, id_gnd_en}));

  p_dp_spk_r7: assert property (@(posedge clk) disable iff (rst)
    dp_spk_r_en |-> (rt_q[5] || rt_q[6]));

  p_data1_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !uart_rx_dp_en |-> data1_o);

  p_data1_pass_r8: assert property (@(posedge clk) disable iff (rst)
    uart_rx_dp_en |-> (data1_o == dp_rx_i));

  p_old_read_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && in_scr) |-> (acc_rdata == scr_q));

  p_stray_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    stray_wr |=> ($stable(scr_q) && $stable(rt_q)));

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (scr_q == '0 && rt_q == '0));

  p_scr_isolated_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && in_scr) |=> $stable(rt_q));

endmodule

bind wsc_reg_bank wsc_reg_bank_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .acc_addr      (acc_addr),
  .acc_wr        (acc_wr),
  .acc_wdata     (acc_wdata),
  .acc_rdata     (acc_rdata),
  .line_state_i  (line_state_i),
  .dp_rx_i       (dp_rx_i),
  .scr_q         (reg_q[0]),
  .rt_q          (reg_q[1]),
  .id_gnd_en     (id_gnd_en),
  .uart_tx_dm_en (uart_tx_dm_en),
  .uart_rx_dp_en (uart_rx_dp_en),
  .spk_left_en   (spk_left_en),
  .spk_right_en  (spk_right_en),
  .mic_en        (mic_en),
  .dp_spk_r_en   (dp_spk_r_en),
  .data1_o       (data1_o)
);

// File: tb/sim_wsc_reg_bank.sv
module sim_wsc_reg_bank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_addr = '0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [1:0] line_state_i = '0;
  logic       dp_rx_i = 1'b0;
  logic id_gnd_en, uart_tx_dm_en, uart_rx_dp_en, spk_left_en;
  logic spk_right_en, mic_en, dp_spk_r_en, data1_o;

  always #2 clk = ~clk;

  wsc_reg_bank u0 (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .line_state_i(line_state_i),
    .dp_rx_i(dp_rx_i), .id_gnd_en(id_gnd_en), .uart_tx_dm_en(uart_tx_dm_en),
    .uart_rx_dp_en(uart_rx_dp_en), .spk_left_en(spk_left_en),
    .spk_right_en(spk_right_en), .mic_en(mic_en), .dp_spk_r_en(dp_spk_r_en),
    .data1_o(data1_o)
  );

  int checks = 0;
  int fails  = 0;
  int scr_m  = 0;
  int rt_m   = 0;
  int seen   = 0;
  int cur_ls = 0;
  int lfsr   = 32'h1ace_b00c;

  function automatic int rnd();
    lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04c1_1db7 : 0);
    return lfsr & 32'h7fff_ffff;
  endfunction

  function automatic int model_rd(int a);
    if (a == 'h15) return cur_ls;
    if (a >= 'h16 && a <= 'h18) return scr_m;
    if (a >= 'h19 && a <= 'h1b) return rt_m;
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (a == 'h15) return "R1";
    if (a >= 'h16 && a <= 'h18) return "R2";
    if (a >= 'h19 && a <= 'h1b) return "R4";
    return "R10";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare against the model,
  // then let the rising edge update both design and model.
  task automatic cyc(bit w, int a, int d);
    int b;
    acc_wr       = w;
    acc_addr     = a[7:0];
    acc_wdata    = d[7:0];
    cur_ls       = rnd() & 3;
    line_state_i = cur_ls[1:0];
    dp_rx_i      = rnd()[0];
    #1;
    seen = int'(acc_rdata);
    if (!rst) begin
      check(rd_tag(a), int'(acc_rdata), model_rd(a));
      check("R6", {mic_en, spk_right_en, spk_left_en, uart_rx_dp_en, uart_tx_dm_en, id_gnd_en},
            (rt_m >> 1) & 'h3f);
      check("R7", int'(dp_spk_r_en), ((rt_m >> 5) & 3) != 0 ? 1 : 0);
      b = ((rt_m >> 3) & 1) != 0 ? int'(dp_rx_i) : 1;
      check("R8", int'(data1_o), b);
    end
    @(posedge clk);
    if (rst) begin
      scr_m = 0; rt_m = 0;
    end else if (w) begin
      case (a)
        'h16: scr_m = d & 'hff;
        'h17: scr_m = (scr_m | d) & 'hff;
        'h18: scr_m = scr_m & ~d & 'hff;
        'h19: rt_m = d & 'h7e;
        'h1a: rt_m = (rt_m | d) & 'h7e;
        'h1b: rt_m = rt_m & ~d & 'h7e;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog (all) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1, 'h16, 'h55);
    rst = 1'b0;
    // R11: defaults after reset
    cyc(0, 'h16, 0); check("R11", seen, 0);
    cyc(0, 'h19, 0); check("R11", seen, 0);
    check("R8", int'(data1_o), 1);
    // R9: same-cycle read shows old value
    cyc(1, 'h16, 'hA5); check("R9", seen, 0);
    cyc(0, 'h17, 0); check("R2", seen, 'hA5);
    // R3: set and clear aliases
    cyc(1, 'h17, 'h0A);
    cyc(0, 'h18, 0); check("R3", seen, 'hAF);
    cyc(1, 'h18, 'h21);
    cyc(0, 'h16, 0); check("R3", seen, 'h8E);
    // R12: scratch traffic leaves routing alone
    check("R12", int'(dp_spk_r_en | id_gnd_en | spk_left_en | uart_tx_dm_en), 0);
    cyc(0, 'h19, 0); check("R12", seen, 0);
    // R5: read-only bits
    cyc(1, 'h19, 'hFF);
    cyc(0, 'h1A, 0); check("R5", seen, 'h7E);
    cyc(1, 'h1B, 'h20); check("R7", int'(dp_spk_r_en), 1);
    cyc(1, 'h1B, 'h40); check("R7", int'(dp_spk_r_en), 0);
    cyc(1, 'h1A, 'h81);
    cyc(0, 'h1B, 0); check("R5", seen, 'h1E);
    cyc(1, 'h1B, 'h08); check("R8", int'(data1_o), 1);
    // R10: debug and unused writes ignored
    cyc(1, 'h15, 'hFF);
    cyc(1, 'h30, 'h55);
    cyc(0, 'h30, 0); check("R10", seen, 0);
    cyc(0, 'h16, 0); check("R10", seen, 'h8E);
    cyc(0, 'h15, 0); check("R1", seen, cur_ls);
    // R4 and R6
    cyc(1, 'h19, 'h12);
    cyc(0, 'h1B, 0); check("R4", seen, 'h12);
    check("R6", int'(id_gnd_en), 1);
    check("R6", int'(spk_left_en), 1);
    // Randomized traffic around the register window, with occasional resets (R11).
    for (int n = 0; n < 5000; n++) begin
      int a;
      a = 'h13 + (rnd() % 11);
      if ((rnd() % 16) == 0) a = rnd() & 'hff;
      rst = ((rnd() % 97) == 0);
      cyc(rnd()[0], a, rnd() & 'hff);
    end
    rst = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule